// File: doc/BRIEF.md
# Burst Request Legality Checker

This block sits ahead of the address channel of an AXI4 master and judges every burst request before it is issued. A request carries a start address, a burst kind, a signed beat count and a transfer size given as a log2 code. One clock after the request strobe, the block returns a verdict strobe with an accept flag and a reason code that says which rule failed. Read and write requests are judged by the same rules, so one instance can serve either channel.

The beat-count limits for each burst kind, the transfer size limit set by the data bus width and the 4 KB page test for incrementing bursts are combined into one decision. When several rules fail, a fixed priority picks the reason that is reported.

Top module: `burst_legality_chk`

## Requirements
- R1: `res_vld` is high in exactly the clock cycle after each cycle in which `req_vld` is high, and low otherwise. Reset clears `res_vld`.
- R2: A beat count of zero or less is rejected with reason 1 (length), whatever the burst kind.
- R3: With kind 1 (incrementing), 1 to 256 beats pass the length rule, and 257 or more beats are rejected with reason 1.
- R4: With kind 0 (fixed), 1 to 16 beats pass the length rule, and 17 or more beats are rejected with reason 1.
- R5: With kind 2 (wrapping), only 2, 4, 8 or 16 beats pass the length rule. Any other count, and any request with kind 3, is rejected with reason 1.
- R6: The size code `req_size` selects 2**code bytes per beat. A code whose byte count is larger than `BUS_BYTES` (8 by default, so codes 4 to 7) is rejected with reason 2 (size).
- R7: An incrementing request whose last byte address, start + (beats-1)*2**code, has a different bit-12-and-up value than the start address is rejected with reason 3 (page). A carry out of the top address bit also counts as a crossing. A burst that ends on the last byte of a page is accepted. Fixed and wrapping bursts never fail this rule.
- R8: When more than one rule fails, the reported reason is length first, then size, then page.
- R9: When `res_vld` is high, `res_ok` is 1 exactly when `res_why` is 0 (none).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe, one request per high cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_kind | input | 2 | Burst kind: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| req_beats | input | LEN_W | Signed beat count |
| req_size | input | 3 | Bytes per beat as a log2 code |
| res_vld | output | 1 | Verdict strobe |
| res_ok | output | 1 | 1 when the request is legal |
| res_why | output | 2 | Reason: 0 none, 1 length, 2 size, 3 page |

## Verification
The hardest cases are the edges of the page test: a burst that ends exactly on the last byte of a page, one that reaches one byte into the next page, and one whose end address carries past the top address bit. The stimulus builds these from start addresses just below a page edge, with beat counts and sizes chosen so the computed end lands on either side of the edge. Priority is tested with requests that break two or three rules together, and back-to-back requests with idle gaps check that each verdict lines up with its own request.

// File: rtl/burst_chk_pkg.sv
package burst_chk_pkg;

    localparam int PAGE_BITS = 12;

    typedef enum logic [1:0] {
        KIND_FIXED = 2'd0,
        KIND_INCR  = 2'd1,
        KIND_WRAP  = 2'd2,
        KIND_RSVD  = 2'd3
    } burst_kind_e;

    typedef enum logic [1:0] {
        WHY_NONE   = 2'd0,
        WHY_LENGTH = 2'd1,
        WHY_SIZE   = 2'd2,
        WHY_PAGE   = 2'd3
    } reject_why_e;

    typedef struct packed {
        logic        vld;
        logic        ok;
        reject_why_e why;
    } verdict_t;

endpackage

// File: rtl/burst_len_rule.sv
module burst_len_rule
    import burst_chk_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int INCR_MAX  = 256,
    parameter int FIXED_MAX = 16,
    parameter int WRAP_MAX  = 16
) (
    input  logic [1:0]              kind,
    input  logic signed [LEN_W-1:0] beats,
    output logic                    len_ok
);
    localparam logic signed [LEN_W-1:0] ZERO     = '0;
    localparam logic signed [LEN_W-1:0] ONE      = LEN_W'(1);
    localparam logic signed [LEN_W-1:0] TWO      = LEN_W'(2);
    localparam logic signed [LEN_W-1:0] INCR_LIM = LEN_W'(INCR_MAX);
    localparam logic signed [LEN_W-1:0] FIX_LIM  = LEN_W'(FIXED_MAX);
    localparam logic signed [LEN_W-1:0] WRAP_LIM = LEN_W'(WRAP_MAX);

    logic positive;
    logic pow2;

    always_comb begin
        positive = (beats > ZERO);
        pow2     = ((beats & (beats - ONE)) == ZERO);
        unique case (kind)
            KIND_FIXED: len_ok = positive && (beats <= FIX_LIM);
            KIND_INCR:  len_ok = positive && (beats <= INCR_LIM);
            KIND_WRAP:  len_ok = (beats >= TWO) && (beats <= WRAP_LIM) && pow2;
            default:    len_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/burst_size_rule.sv
module burst_size_rule #(
    parameter int BUS_BYTES = 8
) (
    input  logic [2:0] size_code,
    output logic       size_ok
);
    logic [7:0] legal;

    for (genvar i = 0; i < 8; i++) begin : g_code
        assign legal[i] = ((1 << i) <= BUS_BYTES);
    end

    assign size_ok = legal[size_code];
endmodule

// File: rtl/burst_page_rule.sv
module burst_page_rule
    import burst_chk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic signed [LEN_W-1:0] beats,
    input  logic [2:0]              size_code,
    output logic                    crosses
);
    localparam int OFS_W = LEN_W + 7;
    localparam int SUM_W = ADDR_W + 1;

    logic [LEN_W-1:0] beats_m1;
    logic [OFS_W-1:0] span;
    logic [SUM_W-1:0] last_byte;
    logic [SUM_W-1:0] first_byte;

    always_comb begin
        beats_m1   = $unsigned(beats) - LEN_W'(1);
        span       = {7'd0, beats_m1} << size_code;
        first_byte = {1'b0, addr};
        last_byte  = first_byte + {{(SUM_W - OFS_W){1'b0}}, span};
        crosses    = (last_byte[SUM_W-1:PAGE_BITS] != first_byte[SUM_W-1:PAGE_BITS]);
    end
endmodule

// File: rtl/burst_legality_chk.sv
module burst_legality_chk
    import burst_chk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 12,
    parameter int BUS_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_vld,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_kind,
    input  logic signed [LEN_W-1:0] req_beats,
    input  logic [2:0]              req_size,
    output logic                    res_vld,
    output logic                    res_ok,
    output logic [1:0]              res_why
);
    logic     len_ok;
    logic     size_ok;
    logic     crosses;
    verdict_t verdict_d, verdict_q;

    burst_len_rule #(.LEN_W(LEN_W)) u_len (
        .kind   (req_kind),
        .beats  (req_beats),
        .len_ok (len_ok)
    );

    burst_size_rule #(.BUS_BYTES(BUS_BYTES)) u_size (
        .size_code (req_size),
        .size_ok   (size_ok)
    );

    burst_page_rule #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_page (
        .addr      (req_addr),
        .beats     (req_beats),
        .size_code (req_size),
        .crosses   (crosses)
    );

    always_comb begin
        verdict_d     = verdict_q;
        verdict_d.vld = req_vld;
        if (req_vld) begin
            if (!len_ok) begin
                verdict_d.why = WHY_LENGTH;
            end else if (!size_ok) begin
                verdict_d.why = WHY_SIZE;
            end else if ((req_kind == KIND_INCR) && crosses) begin
                verdict_d.why = WHY_PAGE;
            end else begin
                verdict_d.why = WHY_NONE;
            end
            verdict_d.ok = (verdict_d.why == WHY_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign res_vld = verdict_q.vld;
    assign res_ok  = verdict_q.ok;
    assign res_why = verdict_q.why;

    assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);
    assert_vld_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !res_vld);
    assert_nonpos_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (req_beats <= 0)) |=> (!res_ok && res_why == WHY_LENGTH));
    assert_incr_257_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == KIND_INCR && req_beats == 257) |=> (res_why == WHY_LENGTH));
    assert_fixed_17_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == KIND_FIXED && req_beats == 17) |=> (res_why == WHY_LENGTH));
    assert_wrap_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == KIND_WRAP && req_beats[0]) |=> (res_why == WHY_LENGTH));
    assert_fixed_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == KIND_FIXED && req_beats == 1 && size_ok) |=> res_ok);
    assert_ok_matches_why_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_ok == (res_why == WHY_NONE)));
endmodule

// File: tb/burst_legality_chk_tb.sv
module burst_legality_chk_tb;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;
    localparam int BUS    = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_vld = 1'b0;
    logic [ADDR_W-1:0]       req_addr = '0;
    logic [1:0]              req_kind = '0;
    logic signed [LEN_W-1:0] req_beats = '0;
    logic [2:0]              req_size = '0;
    logic                    res_vld;
    logic                    res_ok;
    logic [1:0]              res_why;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       ok;
        logic [1:0] why;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    burst_legality_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .req_kind(req_kind), .req_beats(req_beats), .req_size(req_size),
        .res_vld(res_vld), .res_ok(res_ok), .res_why(res_why)
    );

    function automatic logic [1:0] model(input int k, input int beats, input int sz,
                                         input longint a);
        bit len_ok, size_ok, page_bad;
        longint last;
        case (k)
            0: len_ok = (beats >= 1) && (beats <= 16);
            1: len_ok = (beats >= 1) && (beats <= 256);
            2: len_ok = (beats == 2) || (beats == 4) || (beats == 8) || (beats == 16);
            default: len_ok = 1'b0;
        endcase
        size_ok  = ((1 << sz) <= BUS);
        last     = a + longint'(beats - 1) * longint'(1 << sz);
        page_bad = (k == 1) && ((a >> 12) != (last >> 12));
        if (!len_ok) return 2'd1;
        if (!size_ok) return 2'd2;
        if (page_bad) return 2'd3;
        return 2'd0;
    endfunction

    task automatic send(input int k, input int beats, input int sz, input longint a,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_vld   = 1'b1;
        req_kind  = 2'(k);
        req_beats = LEN_W'(beats);
        req_size  = 3'(sz);
        req_addr  = ADDR_W'(a);
        e.why = model(k, beats, sz, a);
        e.ok  = (e.why == 2'd0);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_vld = 1'b0;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && res_vld) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R1: res_vld=1 with no pending request, expected 0");
                end else begin
                    e = sb.pop_front();
                    if (res_ok !== e.ok || res_why !== e.why) begin
                        errors++;
                        $display("FAIL %s: ok=%0b why=%0d, expected ok=%0b why=%0d",
                                 e.tag, res_ok, res_why, e.ok, e.why);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1: watchdog expired, actual hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        checks++;
        if (res_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: res_vld=%0b in reset, expected 0", res_vld);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        send(1, 1, 3, 32'h0, "R3");
        send(1, 256, 0, 32'h1000, "R3");
        send(1, 257, 0, 32'h0, "R3");
        idle(1);
        send(1, 0, 0, 32'h0, "R2");
        send(0, -1, 0, 32'h0, "R2");
        send(2, 0, 2, 32'h0, "R2");
        idle(3);
        send(0, 16, 2, 32'h40, "R4");
        send(0, 17, 2, 32'h40, "R4");
        send(2, 2, 2, 32'h0, "R5");
        send(2, 4, 2, 32'h0, "R5");
        send(2, 8, 3, 32'h0, "R5");
        send(2, 16, 3, 32'hFF0, "R5");
        send(2, 3, 2, 32'h0, "R5");
        send(2, 1, 2, 32'h0, "R5");
        send(2, 32, 2, 32'h0, "R5");
        send(3, 4, 2, 32'h0, "R5");
        idle(2);
        send(1, 4, 3, 32'h0, "R6");
        send(1, 4, 4, 32'h0, "R6");
        send(0, 1, 7, 32'h0, "R6");
        send(1, 1, 3, 32'hFF8, "R7");
        send(1, 2, 3, 32'hFF8, "R7");
        send(1, 32, 3, 32'hF00, "R7");
        send(1, 33, 3, 32'hF00, "R7");
        send(0, 16, 2, 32'hFFC, "R7");
        send(2, 16, 3, 32'h1FF8, "R7");
        send(1, 2, 3, 32'hFFFF_FFF8, "R7");
        send(1, 1, 0, 32'hFFFF_FFFF, "R7");
        idle(1);
        send(1, 300, 5, 32'hFFF, "R8");
        send(1, 4, 4, 32'hFFF, "R8");
        send(3, 0, 6, 32'hFFF, "R8");
        send(1, 256, 3, 32'h800, "R8");
        idle(4);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d verdicts missing, expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule